// File: doc/BRIEF.md
# DRAM Bank Row-State Tracker

This block keeps a live picture of every bank in a DRAM device: whether the bank currently has a row open in its row buffer, and if it does, which row. It sits beside the command bus, watches each command the controller issues, and updates its picture to match. The scheduler reads the outputs to decide whether a request hits an open row, needs an activate first, or needs a precharge before that.

Each command arrives as a one-cycle valid pulse carrying a 3-bit opcode, a bank index and a row address. A static configuration input chooses whether a refresh covers a single bank or the whole device. The tracker does no timing checks and moves no data.

Top module: `bank_row_tracker`

## Requirements
- R1: After a synchronous active-low reset, every bank reads closed and every stored row reads zero.
- R2: An activate (opcode 0) on bank b sets b's open flag and stores the carried row for b; other banks keep their state.
- R3: A single-bank precharge (opcode 1) on bank b clears only b's open flag; other banks keep their flags and rows.
- R4: A precharge-all (opcode 2) clears every bank's open flag, whatever bank index it carries.
- R5: A refresh (opcode 7) with per-bank refresh selected (cfg_ref_per_bank=1) clears only the addressed bank's open flag.
- R6: A refresh with per-bank refresh off (cfg_ref_per_bank=0) clears every bank's open flag.
- R7: Read, read with auto-precharge, write and write with auto-precharge (opcodes 3, 4, 5, 6) leave every open flag and stored row unchanged.
- R8: Without cmd_valid high no state changes, whatever the other command inputs carry; a command updates state on the clock edge where it is valid, visible on the next cycle.
- R9: Closing a bank leaves its stored row unchanged; only an activate writes a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ref_per_bank | input | 1 | 1: refresh closes one bank; 0: refresh closes all banks |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 ACT, 1 PRE, 2 PREA, 3 RD, 4 RDA, 5 WR, 6 WRA, 7 REF |
| cmd_bank | input | BANK_W | Addressed bank |
| cmd_row | input | ROW_W | Row address (used by activate) |
| bank_open | output | NUM_BANKS | Per-bank open flag, bit b for bank b |
| bank_row | output | NUM_BANKS*ROW_W | Stored rows, bank b at bits [b*ROW_W +: ROW_W] |

## Verification
Every result is due exactly one cycle after the command: the bench drives inputs after a falling edge, lets the next rising edge register them, and compares both outputs against its own model in the following low phase. The model is updated in the same step, so a check always covers the cumulative effect of all earlier commands. Random commands, including cycles with cmd_valid low and random payloads, run with both refresh settings, alongside directed cases for reset, precharge-all carrying a nonzero bank, and the highest bank index.

// File: rtl/bank_row_tracker_pkg.sv
// Shared opcode type for the bank row-state tracker.
package bank_row_tracker_pkg;
    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_PRE  = 3'd1,
        OP_PREA = 3'd2,
        OP_RD   = 3'd3,
        OP_RDA  = 3'd4,
        OP_WR   = 3'd5,
        OP_WRA  = 3'd6,
        OP_REF  = 3'd7
    } cmd_op_e;
endpackage

// File: rtl/bank_cmd_decode.sv
// Decodes one bus command into per-bank open and close strobes.
// Assumes cmd_bank < NUM_BANKS; an out-of-range index addresses no bank.
module bank_cmd_decode
    import bank_row_tracker_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 cfg_ref_per_bank,
    output logic [NUM_BANKS-1:0] open_stb,
    output logic [NUM_BANKS-1:0] close_stb
);
    logic [NUM_BANKS-1:0] sel;
    logic act_c, one_close, all_close;

    // Classify the command into open, single close or global close.
    always_comb begin
        act_c     = 1'b0;
        one_close = 1'b0;
        all_close = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op_e'(cmd_op))
                OP_ACT:  act_c     = 1'b1;
                OP_PRE:  one_close = 1'b1;
                OP_PREA: all_close = 1'b1;
                OP_REF: begin
                    one_close = cfg_ref_per_bank;
                    all_close = !cfg_ref_per_bank;
                end
                default: ;
            endcase
        end
    end

    // One-hot bank select and strobes for each bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel[b]       = (cmd_bank == BANK_W'(b));
        assign open_stb[b]  = act_c & sel[b];
        assign close_stb[b] = all_close | (one_close & sel[b]);
    end
endmodule

// File: rtl/bank_state_cell.sv
// Holds the open flag and stored row for one bank.
// Assumes open and close strobes are never both high.
module bank_state_cell #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_stb,
    input  logic             close_stb,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);
    // Update the open flag; activate sets it, close clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         is_open <= 1'b0;
        else if (open_stb)  is_open <= 1'b1;
        else if (close_stb) is_open <= 1'b0;
    end

    // Capture the row only on activate.
    always_ff @(posedge clk) begin
        if (!rst_n)        row_q <= '0;
        else if (open_stb) row_q <= row_in;
    end

    // R2
    open_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_stb |=> (is_open && row_q == $past(row_in)));
    // R9
    close_keeps_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close_stb && !open_stb) |=> (!is_open && $stable(row_q)));
    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_stb && !close_stb) |=> ($stable(is_open) && $stable(row_q)));
endmodule

// File: rtl/bank_row_tracker.sv
// Tracks per-bank row-buffer state from the DRAM command stream.
// Assumes one command per cycle; cfg_ref_per_bank is static between commands.
module bank_row_tracker
    import bank_row_tracker_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_ref_per_bank,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
    logic [NUM_BANKS-1:0] open_stb, close_stb;

    bank_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cfg_ref_per_bank(cfg_ref_per_bank),
        .open_stb(open_stb), .close_stb(close_stb)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_state_cell #(.ROW_W(ROW_W)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .open_stb(open_stb[b]), .close_stb(close_stb[b]),
            .row_in(cmd_row),
            .is_open(bank_open[b]),
            .row_q(bank_row[b*ROW_W +: ROW_W])
        );
    end

    // R4
    prea_closes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |=> (bank_open == '0));
    // R6
    ref_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd7 && !cfg_ref_per_bank) |=> (bank_open == '0));
    // R7
    access_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op inside {3'd3, 3'd4, 3'd5, 3'd6})
        |=> ($stable(bank_open) && $stable(bank_row)));
    // R3
    pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |=> ($countones($past(bank_open) & ~bank_open) <= 1));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (bank_open == '0 && bank_row == '0));
endmodule

// File: tb/bank_row_tracker_tb.sv
module bank_row_tracker_tb;
    localparam int NB = 8;
    localparam int RW = 14;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg = 1'b0;
    logic vld = 1'b0;
    logic [2:0] op = '0;
    logic [BW-1:0] bank = '0;
    logic [RW-1:0] row = '0;
    logic [NB-1:0] bank_open;
    logic [NB*RW-1:0] bank_row;

    logic [NB-1:0] m_open;
    logic [RW-1:0] m_row [NB];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bank_row_tracker #(.NUM_BANKS(NB), .ROW_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ref_per_bank(cfg),
        .cmd_valid(vld), .cmd_op(op), .cmd_bank(bank), .cmd_row(row),
        .bank_open(bank_open), .bank_row(bank_row)
    );

    function automatic logic [NB*RW-1:0] pack_rows();
        logic [NB*RW-1:0] p;
        for (int b = 0; b < NB; b++) p[b*RW +: RW] = m_row[b];
        return p;
    endfunction

    // Model update from the requirements.
    task automatic model(input logic v, input logic [2:0] o, input logic [BW-1:0] bk,
                         input logic [RW-1:0] r, input logic c);
        if (!v) return;
        case (o)
            3'd0: begin m_open[bk] = 1'b1; m_row[bk] = r; end
            3'd1: m_open[bk] = 1'b0;
            3'd2: m_open = '0;
            3'd7: if (c) m_open[bk] = 1'b0; else m_open = '0;
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        checks++;
        if (bank_open !== m_open || bank_row !== pack_rows()) begin
            errors++;
            $display("FAIL %s: open=%b rows=%h expected open=%b rows=%h",
                     req, bank_open, bank_row, m_open, pack_rows());
        end
    endtask

    // Drive one command after a falling edge, check one cycle later.
    task automatic issue(input logic v, input logic [2:0] o, input logic [BW-1:0] bk,
                         input logic [RW-1:0] r, input string req);
        vld = v; op = o; bank = bk; row = r;
        @(posedge clk);
        model(v, o, bk, r, cfg);
        @(negedge clk);
        vld = 1'b0;
        compare(req);
    endtask

    function automatic string req_of(input logic v, input logic [2:0] o, input logic c);
        if (!v) return "R8";
        case (o)
            3'd0: return "R2";
            3'd1: return "R3 R9";
            3'd2: return "R4";
            3'd7: return c ? "R5" : "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_open = '0;
        for (int b = 0; b < NB; b++) m_row[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // Directed corners
        issue(1'b1, 3'd0, 3'd7, 14'h3FFF, "R2");
        issue(1'b1, 3'd0, 3'd0, 14'h0123, "R2");
        issue(1'b0, 3'd1, 3'd7, 14'h0000, "R8");
        issue(1'b1, 3'd5, 3'd7, 14'h1111, "R7");
        issue(1'b1, 3'd1, 3'd7, 14'h2222, "R3 R9");
        issue(1'b1, 3'd0, 3'd3, 14'h0ABC, "R2");
        issue(1'b1, 3'd2, 3'd5, 14'h0000, "R4");
        cfg = 1'b1;
        issue(1'b1, 3'd0, 3'd1, 14'h0055, "R2");
        issue(1'b1, 3'd0, 3'd2, 14'h0066, "R2");
        issue(1'b1, 3'd7, 3'd1, 14'h0000, "R5");
        cfg = 1'b0;
        issue(1'b1, 3'd7, 3'd4, 14'h0000, "R6");

        // Random mix, both refresh settings
        for (int i = 0; i < 2000; i++) begin
            logic v;
            logic [2:0] o;
            if (i % 500 == 0) cfg = $urandom_range(0, 1);
            v = ($urandom_range(0, 9) != 0);
            o = ($urandom_range(0, 2) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
            issue(v, o, 3'($urandom_range(0, NB-1)), 14'($urandom), req_of(v, o, cfg));
        end

        // Reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_open = '0;
        for (int b = 0; b < NB; b++) m_row[b] = '0;
        compare("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule